// File: doc/BRIEF.md
# One-Time-Programmable Word Store Model

This block is a synthesizable stand-in for a 16-bit-wide, one-time-programmable read-only memory. It is meant to sit on the far side of a memory or programmer controller under verification. It takes an address, a 16-bit write word and three active-low strobes: select, drive and burn. Two level flags replace the analog conditions a real part would sense. One says the high programming supply is present. The other says the identification overvoltage is on address line 9. The flags, the strobes and an erase request are sampled on every rising clock edge. On that edge the block decodes one operating mode. One cycle later it presents either a stored word, a two-byte identity code or nothing. "Nothing" is signalled by a low output-valid qualifier, which models a tri-stated bus.

Cells start at one. A burn pulse can only clear bits, so each burn ANDs the incoming word into the addressed location. An erase request walks the whole array and writes ones into it, one word per cycle. During that walk every read returns nothing and every burn is dropped. The array holds 2^DEPTH_W words and is addressed by the low address bits. Higher address bits alias.

Top module: `otp_word_store`

## Requirements
- R1: While reset is held, and in the first cycle after it, `q_vld` is 0 and `q` is 0. After reset every location reads 0xFFFF.
- R2: When `sel_n`=0, `drv_n`=0, `burn_n`=1 and `idv_hi`=0, with no erase active, `q_vld` is 1 on the next cycle and `q` holds the word at index `addr[DEPTH_W-1:0]`. Address bits above `DEPTH_W` are ignored.
- R3: When `sel_n`=1, `q_vld` is 0 on the next cycle, whatever `drv_n` is. A burn with `sel_n`=1 leaves the array unchanged.
- R4: When `sel_n`=0 and `drv_n`=1, `q_vld` is 0 on the next cycle.
- R5: When `vpp_hi`=1, `sel_n`=0 and `burn_n`=0 on a clock edge, and no erase is active, the addressed word becomes its old value AND `din`. `q_vld` is 0 on the next cycle.
- R6: A burn with `vpp_hi`=0 leaves the array unchanged.
- R7: The read of R2 returns the same stored word when `vpp_hi`=1.
- R8: When `idv_hi`=1 and the read strobes of R2 are applied, `q` on the next cycle is 0x0020 if `addr[0]`=0 and 0x008C if `addr[0]`=1. The upper byte is 0.
- R9: An `erase` seen while no scan runs starts a scan. The scan occupies the next 2^DEPTH_W cycles and writes 0xFFFF to index 0, then 1, and so on. While `erase` is high or the scan runs, `q_vld` is 0 on the following cycle. Burns and further erase requests are ignored in that time.
- R10: Whenever `q_vld` is 0, `q` is 0.
- R11: Every output follows the controls present at the previous rising clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Word address. Bit 0 selects the identity byte |
| din | input | 16 | Word to burn |
| sel_n | input | 1 | Active-low device select |
| drv_n | input | 1 | Active-low output drive request |
| burn_n | input | 1 | Active-low burn strobe |
| vpp_hi | input | 1 | Programming supply present |
| idv_hi | input | 1 | Identification overvoltage present on address line 9 |
| erase | input | 1 | Request to start a full-array erase scan |
| q | output | 16 | Read data, zero when not valid |
| q_vld | output | 1 | Output valid; low models high impedance |

## Verification
The bench burns the same word twice with different data and expects the AND of both values. A design that overwrote the word, or set bits, would return the second word alone. It also tries burns that each lack one needed condition: the supply flag, the select, or a quiet array. A design that ignored any of these would show the change on a later read. Reads at aliased addresses catch decoding of the wrong bits. Alternating the identity selector with the supply flag set catches a wrong byte, a non-zero upper byte, or verify taking priority over identity. During an erase scan the bench keeps read strobes active and issues burns and repeated erase requests. A scan that ended one cycle early, let a read through, or restarted would mismatch the cycle-by-cycle model.

// File: rtl/otp_pkg.sv
// Shared definitions for the one-time-programmable word store model.
package otp_pkg;

    // Mode resolved on each clock edge from the control strobes and flags.
    typedef enum logic [2:0] {
        MD_IDLE  = 3'd0,   // deselected, outputs off
        MD_OFF   = 3'd1,   // selected, outputs off
        MD_READ  = 3'd2,   // array word to outputs
        MD_IDENT = 3'd3,   // identity byte to outputs
        MD_BURN  = 3'd4    // clear bits in the addressed word
    } mode_t;

    localparam logic [7:0] ID_MAKER = 8'h20;
    localparam logic [7:0] ID_PART  = 8'h8C;

endpackage

// File: rtl/otp_mode_decode.sv
// Combinational mode decoder.
// Assumes: strobes are active low; hold is high while an erase is requested
// or running, and forces all access off for that time.
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic  sel_n,
    input  logic  drv_n,
    input  logic  burn_n,
    input  logic  vpp_hi,
    input  logic  idv_hi,
    input  logic  hold,
    output mode_t mode
);

    // Priority: select, erase hold, burn strobe, drive strobe, identity.
    always_comb begin
        if (sel_n)
            mode = MD_IDLE;
        else if (hold)
            mode = MD_OFF;
        else if (!burn_n)
            mode = vpp_hi ? MD_BURN : MD_OFF;
        else if (drv_n)
            mode = MD_OFF;
        else if (idv_hi)
            mode = MD_IDENT;
        else
            mode = MD_READ;
    end

endmodule

// File: rtl/otp_erase_seq.sv
// Erase scan sequencer: walks every index once and writes ones there.
// Assumes: a request seen while a scan runs is dropped; the scan starts
// writing on the edge after the request is seen.
module otp_erase_seq #(
    parameter int DEPTH_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               erase,
    output logic               busy,
    output logic [DEPTH_W-1:0] ptr
);

    localparam logic [DEPTH_W-1:0] LAST = '1;

    // Start, advance and finish the scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ptr  <= '0;
        end else if (busy) begin
            if (ptr == LAST)
                busy <= 1'b0;
            ptr <= ptr + 1'b1;
        end else if (erase) begin
            busy <= 1'b1;
            ptr  <= '0;
        end
    end

endmodule

// File: rtl/otp_cell_array.sv
// Flop-based cell array with bit-clearing writes and a ones-writing port.
// Assumes: clearing by the erase scan has priority over a burn; reads are
// combinational and show the contents before the current edge.
module otp_cell_array #(
    parameter int DEPTH_W = 6,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEPTH_W-1:0] idx,
    output logic [DATA_W-1:0]  rd_word,
    input  logic               burn_en,
    input  logic [DATA_W-1:0]  burn_word,
    input  logic               clr_en,
    input  logic [DEPTH_W-1:0] clr_idx
);

    localparam int DEPTH = 1 << DEPTH_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Cell update: reset to ones, scan writes ones, burn clears bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= '1;
        end else if (clr_en) begin
            cells[clr_idx] <= '1;
        end else if (burn_en) begin
            cells[idx] <= cells[idx] & burn_word;
        end
    end

    // Read path.
    assign rd_word = cells[idx];

endmodule

// File: rtl/otp_word_store.sv
// Top level of the one-time-programmable word store model.
// Assumes: every control is sampled on the rising clock edge and the
// outputs are registered, so they reflect the controls one cycle later.
// A low q_vld stands for a tri-stated bus, and q is then zero.
module otp_word_store
    import otp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int DEPTH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              sel_n,
    input  logic              drv_n,
    input  logic              burn_n,
    input  logic              vpp_hi,
    input  logic              idv_hi,
    input  logic              erase,
    output logic [DATA_W-1:0] q,
    output logic              q_vld
);

    mode_t              mode;
    logic               scan_busy;
    logic [DEPTH_W-1:0] scan_ptr;
    logic [DATA_W-1:0]  cell_word;
    logic [DATA_W-1:0]  id_word;
    logic [DEPTH_W-1:0] idx;

    assign idx = addr[DEPTH_W-1:0];

    otp_mode_decode u_dec (
        .sel_n  (sel_n),
        .drv_n  (drv_n),
        .burn_n (burn_n),
        .vpp_hi (vpp_hi),
        .idv_hi (idv_hi),
        .hold   (scan_busy | erase),
        .mode   (mode)
    );

    otp_erase_seq #(.DEPTH_W(DEPTH_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase),
        .busy  (scan_busy),
        .ptr   (scan_ptr)
    );

    otp_cell_array #(.DEPTH_W(DEPTH_W), .DATA_W(DATA_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .rd_word   (cell_word),
        .burn_en   (mode == MD_BURN),
        .burn_word (din),
        .clr_en    (scan_busy),
        .clr_idx   (scan_ptr)
    );

    // Identity word: selected byte in the low half, zeros above.
    always_comb begin
        id_word      = '0;
        id_word[7:0] = addr[0] ? ID_PART : ID_MAKER;
    end

    // Output register: drive data only in the read and identity modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q_vld <= 1'b0;
        end else begin
            unique case (mode)
                MD_READ: begin
                    q     <= cell_word;
                    q_vld <= 1'b1;
                end
                MD_IDENT: begin
                    q     <= id_word;
                    q_vld <= 1'b1;
                end
                default: begin
                    q     <= '0;
                    q_vld <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/otp_word_store_chk.sv
// Protocol checker for otp_word_store, attached by bind below.
// Assumes: scan_busy is the top's internal erase scan flag.
module otp_word_store_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              drv_n,
    input logic              burn_n,
    input logic              idv_hi,
    input logic              erase,
    input logic              scan_busy,
    input logic [DATA_W-1:0] q,
    input logic              q_vld
);

    // R3
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !q_vld);

    // R4
    drive_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && drv_n) |=> !q_vld);

    // R5
    burn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burn_n |=> !q_vld);

    // R8
    ident_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !drv_n && burn_n && idv_hi && !erase && !scan_busy)
        |=> (q_vld && q[DATA_W-1:8] == '0));

    // R9
    scan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_busy || erase) |=> !q_vld);

    // R9
    scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_busy) |-> $past(erase));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_vld |-> (q == '0));

endmodule

bind otp_word_store otp_word_store_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .drv_n     (drv_n),
    .burn_n    (burn_n),
    .idv_hi    (idv_hi),
    .erase     (erase),
    .scan_busy (scan_busy),
    .q         (q),
    .q_vld     (q_vld)
);

// File: tb/sim_otp_word_store.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module sim_otp_word_store;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr, din;
    logic        sel_n, drv_n, burn_n, vpp_hi, idv_hi, erase;
    logic [15:0] q;
    logic        q_vld;

    otp_word_store u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .sel_n(sel_n), .drv_n(drv_n), .burn_n(burn_n),
        .vpp_hi(vpp_hi), .idv_hi(idv_hi), .erase(erase),
        .q(q), .q_vld(q_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [15:0] m_mem [DEPTH];
    bit          m_busy;
    int          m_ptr;
    logic        e_vld;
    logic [15:0] e_q;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check(input string tag);
        n_chk++;
        if (q_vld !== e_vld || q !== e_q) begin
            n_fail++;
            $display("FAIL %s: vld=%0b q=%h expected vld=%0b q=%h",
                     tag, q_vld, q, e_vld, e_q);
        end
    endtask

    // Reference model step, using the inputs and state before the edge.
    task automatic model();
        int  i = int'(addr) % DEPTH;
        bit  hold = m_busy || erase;
        bit  rd = !sel_n && !drv_n && burn_n && !hold;
        e_vld = rd;
        e_q   = !rd ? 16'h0 :
                idv_hi ? (addr[0] ? 16'h008C : 16'h0020) : m_mem[i];
        if (m_busy) begin
            m_mem[m_ptr] = 16'hFFFF;
            if (m_ptr == DEPTH - 1) m_busy = 0;
            m_ptr = (m_ptr + 1) % DEPTH;
        end else if (erase) begin
            m_busy = 1;
            m_ptr  = 0;
        end else if (vpp_hi && !sel_n && !burn_n) begin
            m_mem[i] = m_mem[i] & din;
        end
    endtask

    // One cycle: drive at the falling edge, model at the rising, check at the next falling.
    task automatic cyc(input logic s, input logic d, input logic b,
                       input logic v, input logic id, input logic e,
                       input logic [15:0] a, input logic [15:0] w,
                       input string tag);
        sel_n = s; drv_n = d; burn_n = b; vpp_hi = v; idv_hi = id;
        erase = e; addr = a; din = w;
        @(posedge clk);
        model();
        @(negedge clk);
        check(tag);
    endtask

    task automatic rd(input logic [15:0] a, input logic v, input string tag);
        cyc(0, 0, 1, v, 0, 0, a, 16'h0, tag);
    endtask

    task automatic burn(input logic s, input logic v, input logic [15:0] a,
                        input logic [15:0] w, input string tag);
        cyc(s, 1, 0, v, 0, 0, a, w, tag);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) m_mem[k] = 16'hFFFF;
        m_busy = 0; m_ptr = 0;
        rst_n = 0; sel_n = 1; drv_n = 1; burn_n = 1; vpp_hi = 0;
        idv_hi = 0; erase = 0; addr = 0; din = 0;
        repeat (3) @(negedge clk);
        e_vld = 0; e_q = 0;
        check("R1 in reset");
        rst_n = 1;
        cyc(1, 1, 1, 0, 0, 0, 16'h0, 16'h0, "R1 first cycle");

        // R1: fresh array reads all ones; R2 plain reads
        for (int k = 0; k < DEPTH; k++) rd(16'(k), 0, "R1 R2 blank read");

        // R5: bits only clear
        burn(0, 1, 16'd5, 16'hA5A5, "R5 burn");
        rd(16'd5, 0, "R5 readback");
        burn(0, 1, 16'd5, 16'h0FF0, "R5 second burn");
        rd(16'd5, 0, "R5 and-merge");
        burn(0, 1, 16'd5, 16'hFFFF, "R5 ones burn");
        rd(16'd5, 0, "R5 no set");

        // R6: no supply flag
        burn(0, 0, 16'd6, 16'h0000, "R6 burn no supply");
        rd(16'd6, 0, "R6 untouched");

        // R3: deselected burn and standby
        burn(1, 1, 16'd7, 16'h0000, "R3 burn deselected");
        rd(16'd7, 0, "R3 untouched");
        cyc(1, 0, 1, 0, 0, 0, 16'd5, 16'h0, "R3 standby drive low");
        cyc(1, 0, 1, 1, 1, 0, 16'd5, 16'h0, "R3 standby flags set");

        // R4: drive off
        cyc(0, 1, 1, 0, 0, 0, 16'd5, 16'h0, "R4 drive off");

        // R7: verify with supply flag
        rd(16'd5, 1, "R7 verify");

        // R2: aliasing of upper address bits
        rd(16'd5 + 16'd192, 0, "R2 alias");
        rd(16'hFFC5, 1, "R2 alias high");

        // R8: identity bytes, also with supply flag and other address bits
        cyc(0, 0, 1, 0, 1, 0, 16'h0000, 16'h0, "R8 maker byte");
        cyc(0, 0, 1, 0, 1, 0, 16'h0001, 16'h0, "R8 part byte");
        cyc(0, 0, 1, 1, 1, 0, 16'h0005, 16'h0, "R8 part with supply");
        cyc(0, 0, 1, 1, 1, 0, 16'h0004, 16'h0, "R8 maker with supply");
        cyc(0, 1, 1, 0, 1, 0, 16'h0001, 16'h0, "R4 R8 identity drive off");

        // R9: erase scan with reads, burns and repeat requests inside it
        burn(0, 1, 16'd0, 16'h1234, "R9 pre burn 0");
        burn(0, 1, 16'd63, 16'h4321, "R9 pre burn 63");
        cyc(0, 0, 1, 0, 0, 1, 16'd0, 16'h0, "R9 erase request");
        for (int k = 0; k < DEPTH; k++) begin
            if (k == 10)      burn(0, 1, 16'd2, 16'h0000, "R9 burn in scan");
            else if (k == 20) cyc(0, 0, 1, 0, 0, 1, 16'd0, 16'h0, "R9 erase in scan");
            else if (k == 30) cyc(0, 0, 1, 0, 1, 0, 16'd1, 16'h0, "R9 identity in scan");
            else              rd(16'(k), 0, "R9 read in scan");
        end
        for (int k = 0; k < DEPTH; k++) rd(16'(k), 0, "R9 post erase");

        // R10 R11 mixed traffic
        for (int k = 0; k < 400; k++) begin
            cyc(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 4) != 0,
                ($urandom % 2) == 1, ($urandom % 5) == 0, ($urandom % 80) == 0,
                16'($urandom), 16'($urandom), "R10 R11 mixed");
        end
        for (int k = 0; k < DEPTH + 2; k++) rd(16'(k), 0, "R11 final sweep");

        summary();
        $finish;
    end

endmodule